// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

This block is one channel of a general-purpose timer. It watches an external free-running counter and its overflow pulse, and a six-bit configuration word selects what the channel does. It can hand the pin back to the port at a fixed idle level, capture the counter value on chosen pin edges, or drive the pin on compare matches for plain or buffered PWM. A toggle on overflow can be enabled, and a maximum-duty override can force the output high.

The pin input passes through a two-flop synchroniser. Edge detection is held off until that synchroniser has refilled after capture mode is entered. In buffered mode, software writes a shadow compare value that moves into the active compare register only at a counter overflow, so a duty change never cuts a period short. Capture events and compare matches raise a sticky channel flag, and software clears it with a one-cycle pulse.

Top module: `tmr_chan`

## Requirements
- R1: After reset all configuration bits are 0, the pin is owned by the port (`pin_timer`=0), `pin_out`=1, `chan_flag`=0 and `cap_val`=0.
- R2: Configuration word `cfg_wdata` is {modeB[5], modeA[4], edgeB[3], edgeA[2], tov[1], maxd[0]}. With edgeB/edgeA = 00, `pin_out` equals the inverse of modeA from the second clock edge after the write, whatever modeB is.
- R3: With modeB=modeA=0, edge code 01 captures on a rising pin edge, 10 on a falling edge and 11 on both. The capture loads `cap_val` with `cnt_val` on the third clock edge after the pin changes. An edge of the other polarity changes nothing.
- R4: After capture mode is entered, pin edges are ignored until two clock edges have passed with capture mode active.
- R5: With modeB=0, modeA=1, a match (`cnt_val` equals the active compare value) toggles (code 01), clears (10) or sets (11) `pin_out` on the next edge. An unbuffered compare write takes effect at once.
- R6: A capture or a compare match sets `chan_flag`. A `flag_clr` pulse clears it, and a setting event in the same cycle wins over the clear.
- R7: With tov=1 in a compare mode, every `cnt_ovf` toggles `pin_out`. In capture mode, tov and `cnt_ovf` leave `pin_out` unchanged.
- R8: With tov=1, an overflow that coincides with a match toggles the pin, and the match action is dropped.
- R9: With modeB=1, a compare write goes to a shadow register. The active compare value is replaced only at the next `cnt_ovf`.
- R10: In a compare mode with tov=0, maxd=1 forces `pin_out` to 1 from the first overflow after maxd is set, until the first overflow after it is cleared.
- R11: `pin_timer` is 1 whenever the edge code is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CW | Free-running counter value |
| cnt_ovf | input | 1 | One-cycle counter overflow pulse |
| pin_in | input | 1 | Raw channel pin level |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Mode, edge, tov and maxd bits |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CW | Compare value |
| flag_clr | input | 1 | Clear pulse for the channel flag |
| pin_out | output | 1 | Level driven onto the pin |
| pin_timer | output | 1 | 1 when the timer owns the pin |
| cap_val | output | CW | Last captured counter value |
| chan_flag | output | 1 | Capture/compare event flag |

## Verification
Capture runs with rising-only, falling-only and both-edge codes. Each code gets both edge polarities at distinct counter values, so the stored value shows which edge was taken. Compare runs with toggle, clear and set actions, and the overflow-plus-match case is set up where toggle and the match action give different levels. Buffered mode is tried with a shadow value matched before and after an overflow. The maximum-duty override is checked at its turn-on and turn-off overflows, and an edge that arrives while the synchroniser refills must not capture.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_ovf,
  input  logic          pin_in,
  input  logic          cfg_wr,
  input  logic [5:0]    cfg_wdata,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          flag_clr,
  output logic          pin_out,
  output logic          pin_timer,
  output logic [CW-1:0] cap_val,
  output logic          chan_flag
);

  logic          msb_q, msa_q, elsb_q, elsa_q, tov_q, maxd_q;
  logic [CW-1:0] cmp_shadow, cmp_act, cap_q;
  logic          s1, s2, s3;
  logic [1:0]    fill;
  logic          out_q, max_eff, flag_q;

  wire [1:0] els      = {elsb_q, elsa_q};
  wire       pre_mode = (els == 2'b00);
  wire       cap_mode = !pre_mode && !msb_q && !msa_q;
  wire       buf_mode = !pre_mode && msb_q;
  wire       cmp_mode = !pre_mode && (msb_q || msa_q);
  wire       armed    = (fill == 2'd2);
  wire       rise     = s2 & ~s3;
  wire       fall     = ~s2 & s3;
  wire       cap_hit  = cap_mode && armed && ((elsa_q && rise) || (elsb_q && fall));
  wire       match    = cmp_mode && (cnt_val == cmp_act);
  wire       ovf_tog  = cmp_mode && tov_q && cnt_ovf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {msb_q, msa_q, elsb_q, elsa_q, tov_q, maxd_q} <= '0;
    else if (cfg_wr) {msb_q, msa_q, elsb_q, elsa_q, tov_q, maxd_q} <= cfg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {s1, s2, s3} <= '0;
      fill <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
      if (!cap_mode) fill <= '0;
      else if (!armed) fill <= fill + 2'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_shadow <= '0;
      cmp_act    <= '0;
    end else begin
      if (cmp_wr) cmp_shadow <= cmp_wdata;
      if (cmp_wr && !buf_mode) cmp_act <= cmp_wdata;
      else if (buf_mode && cnt_ovf) cmp_act <= cmp_shadow;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_q <= 1'b1;
    else if (pre_mode) out_q <= ~msa_q;
    else if (ovf_tog) out_q <= ~out_q;
    else if (match)
      case (els)
        2'b01:   out_q <= ~out_q;
        2'b10:   out_q <= 1'b0;
        default: out_q <= 1'b1;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) max_eff <= 1'b0;
    else if (cnt_ovf) max_eff <= maxd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= 1'b0;
    else if (cap_hit || match) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap_q <= '0;
    else if (cap_hit) cap_q <= cnt_val;

  assign pin_out   = out_q | (cmp_mode & ~tov_q & max_eff);
  assign pin_timer = !pre_mode;
  assign cap_val   = cap_q;
  assign chan_flag = flag_q;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic          cnt_ovf,
  input logic          flag_clr,
  input logic          pin_out,
  input logic          chan_flag,
  input logic [CW-1:0] cap_val,
  input logic [1:0]    els,
  input logic          msa_q,
  input logic          tov_q,
  input logic          cap_mode,
  input logic          cmp_mode,
  input logic          buf_mode,
  input logic [CW-1:0] cmp_act
);

  // R2
  preset_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (els == 2'b00 && !cfg_wr) |=> (pin_out == !$past(msa_q)));

  // R3
  cap_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_val) |-> chan_flag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_flag && !flag_clr) |=> chan_flag);

  // R7
  cap_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && !cfg_wr) |=> $stable(pin_out));

  // R8
  ovf_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && tov_q && cnt_ovf && !cfg_wr) |=> (pin_out != $past(pin_out)));

  // R9
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && !cnt_ovf && !cfg_wr) |=> $stable(cmp_act));

endmodule

bind tmr_chan tmr_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cnt_ovf(cnt_ovf),
  .flag_clr(flag_clr), .pin_out(pin_out), .chan_flag(chan_flag),
  .cap_val(cap_val), .els(els), .msa_q(msa_q), .tov_q(tov_q),
  .cap_mode(cap_mode), .cmp_mode(cmp_mode), .buf_mode(buf_mode),
  .cmp_act(cmp_act)
);

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;
  localparam int CW = 16;
  localparam time T_CLK = 10ns;

  logic          clk = 0, rst_n = 0;
  logic [CW-1:0] cnt_val = '0;
  logic          cnt_ovf = 0, pin_in = 0, cfg_wr = 0, cmp_wr = 0, flag_clr = 0;
  logic [5:0]    cfg_wdata = '0;
  logic [CW-1:0] cmp_wdata = '0;
  logic          pin_out, pin_timer, chan_flag;
  logic [CW-1:0] cap_val;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  tmr_chan #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
    .pin_in(pin_in), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .flag_clr(flag_clr),
    .pin_out(pin_out), .pin_timer(pin_timer), .cap_val(cap_val),
    .chan_flag(chan_flag)
  );

  always #(T_CLK/2) clk = ~clk;

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(logic [5:0] v);
    cfg_wr = 1; cfg_wdata = v; tick(); cfg_wr = 0;
  endtask

  task automatic wr_cmp(logic [CW-1:0] v);
    cmp_wr = 1; cmp_wdata = v; tick(); cmp_wr = 0;
  endtask

  task automatic clr_flag();
    flag_clr = 1; tick(); flag_clr = 0;
  endtask

  task automatic ovf_pulse();
    cnt_val = '0; cnt_ovf = 1; tick(); cnt_ovf = 0; cnt_val = 16'h0001;
  endtask

  task automatic hit(logic [CW-1:0] v);
    cnt_val = v; tick(); cnt_val = v + 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 pin_out", pin_out, 1);
    chk("R1 pin_timer", pin_timer, 0);
    chk("R1 flag", chan_flag, 0);
    chk("R1 cap", cap_val, 0);
  endtask

  task automatic t_preset();
    wr_cfg(6'b01_00_00); tick();
    chk("R2 low", pin_out, 0);
    chk("R2 port owned", pin_timer, 0);
    wr_cfg(6'b10_00_00); tick();
    chk("R2 high modeB dc", pin_out, 1);
  endtask

  task automatic t_fill();
    cnt_val = 16'h0011; pin_in = 1;
    wr_cfg(6'b00_01_00); tick(4);
    chk("R4 no capture", chan_flag, 0);
    chk("R4 cap", cap_val, 0);
    chk("R11 owned", pin_timer, 1);
  endtask

  task automatic t_cap_rise();
    cnt_val = 16'h0123; pin_in = 0; tick(4);
    chk("R3 fall ignored", chan_flag, 0);
    pin_in = 1; tick(4);
    chk("R3 rise cap", cap_val, 16'h0123);
    chk("R6 flag set", chan_flag, 1);
    clr_flag();
    chk("R6 flag clr", chan_flag, 0);
    wr_cfg(6'b00_01_10);
    ovf_pulse(); tick(2);
    chk("R7 capture ignores tov", pin_out, 1);
  endtask

  task automatic t_cap_fall();
    wr_cfg(6'b00_10_00);
    cnt_val = 16'h0200; pin_in = 0; tick(4);
    chk("R3 fall cap", cap_val, 16'h0200);
    clr_flag();
    cnt_val = 16'h0300; pin_in = 1; tick(4);
    chk("R3 rise ignored", cap_val, 16'h0200);
    chk("R3 rise no flag", chan_flag, 0);
  endtask

  task automatic t_cap_both();
    wr_cfg(6'b00_11_00);
    cnt_val = 16'h0400; pin_in = 0; tick(4);
    chk("R3 both fall", cap_val, 16'h0400);
    clr_flag();
    cnt_val = 16'h0500; pin_in = 1; tick(4);
    chk("R3 both rise", cap_val, 16'h0500);
    clr_flag();
    cnt_val = 16'h0600; pin_in = 0; tick(2);
    flag_clr = 1; tick(); flag_clr = 0;
    chk("R6 set beats clear", chan_flag, 1);
    chk("R3 cap 600", cap_val, 16'h0600);
    clr_flag();
  endtask

  task automatic t_cmp();
    cnt_val = 16'h0010;
    wr_cfg(6'b01_01_00);
    wr_cmp(16'h0040);
    chk("R5 idle", pin_out, 1);
    hit(16'h0040);
    chk("R5 toggle", pin_out, 0);
    chk("R6 match flag", chan_flag, 1);
    clr_flag();
    wr_cfg(6'b01_11_00);
    hit(16'h0040);
    chk("R5 set", pin_out, 1);
    wr_cfg(6'b01_10_00);
    hit(16'h0040);
    chk("R5 clear", pin_out, 0);
    hit(16'h0050);
    chk("R5 no match", pin_out, 0);
  endtask

  task automatic t_tov();
    wr_cfg(6'b01_10_10);
    ovf_pulse();
    chk("R7 ovf toggle", pin_out, 1);
    wr_cfg(6'b01_11_10);
    cnt_val = 16'h0040; cnt_ovf = 1; tick(); cnt_ovf = 0; cnt_val = 16'h0041;
    chk("R8 ovf beats match", pin_out, 0);
  endtask

  task automatic t_buf();
    wr_cfg(6'b10_01_00);
    wr_cmp(16'h0030);
    hit(16'h0030);
    chk("R9 shadow not active", pin_out, 0);
    ovf_pulse();
    chk("R7 no toggle tov0", pin_out, 0);
    hit(16'h0030);
    chk("R9 active after ovf", pin_out, 1);
  endtask

  task automatic t_max();
    wr_cfg(6'b01_10_01);
    wr_cmp(16'h0040);
    hit(16'h0040);
    chk("R10 not before ovf", pin_out, 0);
    ovf_pulse();
    chk("R10 forced high", pin_out, 1);
    hit(16'h0040);
    chk("R10 holds over clear", pin_out, 1);
    wr_cfg(6'b01_10_00);
    chk("R10 held until ovf", pin_out, 1);
    ovf_pulse();
    chk("R10 released", pin_out, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    t_reset();
    t_preset();
    t_fill();
    t_cap_rise();
    t_cap_fall();
    t_cap_both();
    t_cmp();
    t_tov();
    t_buf();
    t_max();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule